// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditionally executed instruction or branch takes effect. It takes a 4-bit condition selector and the four status flags: negative (N), zero (Z), carry (C) and overflow (V). It reports a combinational `execute` decision in the same cycle. The conditions cover equality, carry, sign, overflow, unsigned ordering and signed ordering. One code means always and one code means never.

A registered stage then gates three requested side effects with that decision: a result write, a memory write and a branch. An instruction whose condition fails leaves no trace at these outputs. Decode, the program counter and the flag register sit outside this block.

Top module: `cond_gate_unit`

## Requirements
- R1: Code 0 passes when Z=1; code 1 passes when Z=0.
- R2: Code 2 passes when C=1; code 3 passes when C=0.
- R3: Code 4 passes when N=1; code 5 passes when N=0.
- R4: Code 6 passes when V=1; code 7 passes when V=0.
- R5: Code 8 (unsigned higher) passes when C=1 and Z=0; code 9 (unsigned lower or same) passes when C=0 or Z=1.
- R6: Code 10 (signed greater or equal) passes when N equals V; code 11 (signed less than) passes when N differs from V.
- R7: Code 12 (signed greater than) passes when Z=0 and N equals V; code 13 (signed less or equal) passes when Z=1 or N differs from V.
- R8: Code 14 passes for every flag value; code 15 never passes.
- R9: `execute` is combinational and equals `inValid` AND the selected condition; with `inValid` low it is 0.
- R10: After each rising clock edge, `resultWrEn`, `memWrEn` and `branchTaken` each equal `execute` AND their own request (`reqResultWr`, `reqMemWr`, `reqBranch`), as sampled at that edge.
- R11: When `execute` is 0 at an edge, all three registered outputs are 0 after it, whatever the requests.
- R12: While `rst_n` is low, the three registered outputs are 0, and they clear as soon as reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An instruction is presented this cycle |
| condCode | input | 4 | Condition selector, codes per R1 to R8 |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| reqResultWr | input | 1 | Instruction wants to write its result |
| reqMemWr | input | 1 | Instruction wants to write memory |
| reqBranch | input | 1 | Instruction is a branch |
| execute | output | 1 | Combinational condition decision |
| resultWrEn | output | 1 | Registered, gated result write enable |
| memWrEn | output | 1 | Registered, gated memory write enable |
| branchTaken | output | 1 | Registered, gated branch taken |

## Verification
A hand-built table first applies flag values chosen to sit on either side of each predicate. Examples are carry set with zero set for the unsigned pair, and N equal to V with and without Z for the signed pair, so a swapped flag or an inverted term shows up. A sweep then tries all 256 pairs of code and flags, with the request bits varied along the way. This separates code ordering mistakes and gating slips on any single output. Directed cases cover the remaining behaviour: `inValid` low under the always code, the never code with every request raised, a failing condition with all requests set, and reset asserted while outputs are high.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;
  localparam int COND_W    = 4;
  localparam int NUM_CODES = 1 << COND_W;
  localparam int NUM_PAIRS = 7;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET = 4'd0,  CC_ZCLR = 4'd1,
    CC_CSET = 4'd2,  CC_CCLR = 4'd3,
    CC_NSET = 4'd4,  CC_NCLR = 4'd5,
    CC_VSET = 4'd6,  CC_VCLR = 4'd7,
    CC_UGT  = 4'd8,  CC_ULE  = 4'd9,
    CC_SGE  = 4'd10, CC_SLT  = 4'd11,
    CC_SGT  = 4'd12, CC_SLE  = 4'd13,
    CC_ALL  = 4'd14, CC_NONE = 4'd15
  } cond_code_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic exec;
    logic resWr;
    logic memWr;
    logic brTake;
  } gate_strobe_t;
endpackage

// File: rtl/cond_pred_dp.sv
module cond_pred_dp
  import cond_gate_pkg::*;
#(
  parameter int CW = COND_W
) (
  input  flags_t        flags,
  input  logic [CW-1:0] condCode,
  output logic          condPass
);
  localparam int NC = 1 << CW;

  logic [NC-1:0] predVec;
  logic [NUM_PAIRS-1:0] basePred;

  // Each even code is a base predicate; the odd code next to it is its inverse.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (p == 0) begin : g_z
      assign basePred[p] = flags.z;
    end else if (p == 1) begin : g_c
      assign basePred[p] = flags.c;
    end else if (p == 2) begin : g_n
      assign basePred[p] = flags.n;
    end else if (p == 3) begin : g_v
      assign basePred[p] = flags.v;
    end else if (p == 4) begin : g_ugt
      assign basePred[p] = flags.c & ~flags.z;
    end else if (p == 5) begin : g_sge
      assign basePred[p] = ~(flags.n ^ flags.v);
    end else begin : g_sgt
      assign basePred[p] = ~flags.z & ~(flags.n ^ flags.v);
    end
    assign predVec[2*p]   = basePred[p];
    assign predVec[2*p+1] = ~basePred[p];
  end

  for (genvar k = 2*NUM_PAIRS; k < NC; k++) begin : g_fixed
    assign predVec[k] = (k == int'(CC_ALL));
  end

  assign condPass = predVec[condCode];

  always_comb begin
    if (!$isunknown(flags)) begin
      p_gt_implies_ge_r7: assert (!predVec[CC_SGT] || predVec[CC_SGE])
        else $error("signed greater-than without greater-or-equal");
      p_ugt_implies_cset_r5: assert (!predVec[CC_UGT] || predVec[CC_CSET])
        else $error("unsigned higher without carry");
      p_le_covers_lt_r6: assert (!predVec[CC_SLT] || predVec[CC_SLE])
        else $error("signed less-than without less-or-equal");
      p_eq_in_ule_r1: assert (!predVec[CC_ZSET] || predVec[CC_ULE])
        else $error("zero set but unsigned lower-or-same fails");
    end
  end
endmodule

// File: rtl/cond_gate_ctrl.sv
module cond_gate_ctrl
  import cond_gate_pkg::*;
(
  input  logic         inValid,
  input  logic         condPass,
  input  logic         reqResultWr,
  input  logic         reqMemWr,
  input  logic         reqBranch,
  output gate_strobe_t strobe
);
  logic execNow;

  assign execNow = inValid & condPass;

  always_comb begin
    strobe.exec   = execNow;
    strobe.resWr  = execNow & reqResultWr;
    strobe.memWr  = execNow & reqMemWr;
    strobe.brTake = execNow & reqBranch;
  end
endmodule

// File: rtl/cond_gate_regs.sv
module cond_gate_regs
  import cond_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  gate_strobe_t strobe,
  input  logic         reqResultWr,
  output logic         resultWrEn,
  output logic         memWrEn,
  output logic         branchTaken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultWrEn  <= 1'b0;
      memWrEn     <= 1'b0;
      branchTaken <= 1'b0;
    end else begin
      resultWrEn  <= strobe.resWr;
      memWrEn     <= strobe.memWr;
      branchTaken <= strobe.brTake;
    end
  end

  p_fail_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.exec |=> (!resultWrEn && !memWrEn && !branchTaken))
    else $error("outputs raised after a failed condition");

  p_pass_writes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.exec && reqResultWr) |=> resultWrEn)
    else $error("result write lost after passing condition");
endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
  import cond_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [COND_W-1:0] condCode,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic              reqResultWr,
  input  logic              reqMemWr,
  input  logic              reqBranch,
  output logic              execute,
  output logic              resultWrEn,
  output logic              memWrEn,
  output logic              branchTaken
);
  flags_t       flagsIn;
  logic         condPass;
  gate_strobe_t strobe;

  assign flagsIn = '{n: flagN, z: flagZ, c: flagC, v: flagV};

  cond_pred_dp #(.CW(COND_W)) pred_i (
    .flags    (flagsIn),
    .condCode (condCode),
    .condPass (condPass)
  );

  cond_gate_ctrl ctrl_i (
    .inValid     (inValid),
    .condPass    (condPass),
    .reqResultWr (reqResultWr),
    .reqMemWr    (reqMemWr),
    .reqBranch   (reqBranch),
    .strobe      (strobe)
  );

  cond_gate_regs regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reqResultWr (reqResultWr),
    .resultWrEn  (resultWrEn),
    .memWrEn     (memWrEn),
    .branchTaken (branchTaken)
  );

  assign execute = strobe.exec;

  p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == CC_NONE) |-> !execute)
    else $error("never code executed");

  p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && condCode == CC_ALL) |-> execute)
    else $error("always code did not execute");

  p_invalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> !execute)
    else $error("execute without a valid instruction");
endmodule

// File: tb/cond_gate_unit_tb_top.sv
module cond_gate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // Entry: {code[3:0], N, Z, C, V, expected pass}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd0,  4'b0100, 1'b1},  // R1 Z set
    {4'd0,  4'b0000, 1'b0},  // R1
    {4'd1,  4'b0000, 1'b1},  // R1
    {4'd2,  4'b0010, 1'b1},  // R2
    {4'd3,  4'b0010, 1'b0},  // R2
    {4'd4,  4'b1000, 1'b1},  // R3
    {4'd5,  4'b1000, 1'b0},  // R3
    {4'd6,  4'b0001, 1'b1},  // R4
    {4'd7,  4'b0000, 1'b1},  // R4
    {4'd8,  4'b0010, 1'b1},  // R5 C=1 Z=0
    {4'd8,  4'b0110, 1'b0},  // R5 C=1 Z=1
    {4'd9,  4'b0000, 1'b1},  // R5
    {4'd9,  4'b0010, 1'b0},  // R5
    {4'd10, 4'b1001, 1'b1},  // R6 N=V=1
    {4'd10, 4'b1000, 1'b0},  // R6
    {4'd11, 4'b0001, 1'b1},  // R6
    {4'd12, 4'b0000, 1'b1},  // R7
    {4'd12, 4'b0100, 1'b0},  // R7 Z set
    {4'd13, 4'b1000, 1'b1},  // R7 N!=V
    {4'd13, 4'b0000, 1'b0},  // R7
    {4'd14, 4'b1111, 1'b1},  // R8
    {4'd15, 4'b0000, 1'b0}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] condCode = 4'd0;
  logic flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic reqResultWr = 1'b0, reqMemWr = 1'b0, reqBranch = 1'b0;
  logic execute, resultWrEn, memWrEn, branchTaken;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .condCode(condCode),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .reqResultWr(reqResultWr), .reqMemWr(reqMemWr), .reqBranch(reqBranch),
    .execute(execute), .resultWrEn(resultWrEn), .memWrEn(memWrEn),
    .branchTaken(branchTaken)
  );

  function automatic logic refPass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int reqTag(input logic [3:0] c);
    return (c >= 4'd14) ? 8 : (int'(c) / 2 + 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Apply at negedge, check execute, then registered outputs at next negedge.
  task automatic applyAndCheck(input logic vld, input logic [3:0] c, input logic [3:0] f,
                               input logic [2:0] rq, input logic expPass, input string req);
    @(negedge clk);
    inValid = vld; condCode = c; {flagN, flagZ, flagC, flagV} = f;
    {reqResultWr, reqMemWr, reqBranch} = rq;
    #1;
    check(req, execute, vld & expPass, "execute");
    @(negedge clk);
    check("R10", resultWrEn,  vld & expPass & rq[2], "resultWrEn");
    check("R10", memWrEn,     vld & expPass & rq[1], "memWrEn");
    check("R10", branchTaken, vld & expPass & rq[0], "branchTaken");
  endtask

  initial begin
    // R12: reset state
    #(CLK_PERIOD*2 + 1);
    check("R12", resultWrEn, 1'b0, "resultWrEn in reset");
    check("R12", memWrEn, 1'b0, "memWrEn in reset");
    check("R12", branchTaken, 1'b0, "branchTaken in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk, R1..R8 (tag by code)
    for (int i = 0; i < NVEC; i++) begin
      applyAndCheck(1'b1, VEC[i][8:5], VEC[i][4:1], 3'b111, VEC[i][0],
                    $sformatf("R%0d", reqTag(VEC[i][8:5])));
    end

    // Exhaustive sweep against reference predicates
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [2:0] rq;
        rq = 3'(c + f);
        applyAndCheck(1'b1, 4'(c), 4'(f), rq, refPass(4'(c), 4'(f)),
                      $sformatf("R%0d", reqTag(4'(c))));
      end
    end

    // R9: invalid instruction with always code does nothing
    applyAndCheck(1'b0, 4'd14, 4'b0000, 3'b111, 1'b1, "R9");

    // R8: never code with all requests raised
    applyAndCheck(1'b1, 4'd15, 4'b1111, 3'b111, 1'b0, "R8");

    // R11: failing condition right after a passing one clears every output
    applyAndCheck(1'b1, 4'd14, 4'b0000, 3'b111, 1'b1, "R8");
    applyAndCheck(1'b1, 4'd0, 4'b0000, 3'b111, 1'b0, "R11");
    check("R11", resultWrEn | memWrEn | branchTaken, 1'b0, "any output after fail");

    // R12: asynchronous reset clears high outputs
    applyAndCheck(1'b1, 4'd14, 4'b0000, 3'b111, 1'b1, "R8");
    rst_n = 1'b0;
    #1;
    check("R12", resultWrEn, 1'b0, "resultWrEn after async reset");
    check("R12", memWrEn, 1'b0, "memWrEn after async reset");
    check("R12", branchTaken, 1'b0, "branchTaken after async reset");
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule